// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block keeps the interrupt context of a single hardware processor thread and answers one question for every notification it is shown: is this thread the target, and if so, at which privilege ring? The context holds four rings: user, OS, hypervisor pool and hypervisor physical. Each ring has a valid bit. The OS and pool rings each hold a stored virtual-target identifier. The user ring holds a logical-server number. The physical ring stores no identifier. It is compared against an identifier hardwired from the thread's processor identification value, and the layout of that identifier depends on a static block-grouping mode.

Software loads the rings through a simple write port, one ring per write. A notification is presented for one cycle on the request inputs. These carry a format bit, a target block and index, an ignore bit and a logical-server number. One cycle later the block returns a result strobe with a hit flag and a two-bit ring code. A surrounding presenter uses this result to pick the thread and ring that are signalled.

Top module: `thread_ctx_matcher`

## Requirements
- R1: After reset, res_vld, res_hit and res_ring are 0 and all four rings are invalid, so any request then reports a miss.
- R2: When wr_en is high, the ring selected by wr_ring (0 user, 1 OS, 2 pool, 3 physical) takes wr_vld as its valid bit and wr_data as its stored word. The user ring keeps wr_data[11:0] as its logical-server number. The new contents apply to requests from the next cycle on. A request in the same cycle as the write sees the old contents.
- R3: The request target identifier is req_blk shifted left by 19, ORed with req_idx. The OS and pool rings match when they are valid and their stored 23-bit word equals this identifier.
- R4: With grp_mode = 0, thr_hw_id is 23 bits. Bit 7 is 1, the chip number sits in bits 14..11, the thread number sits in bits 6..0, and every other bit is 0. The chip number is proc_id[11:8] and the thread number is proc_id[6:0].
- R5: With grp_mode = 1, thr_hw_id has a 1 in bit 11, the chip number in bits 10..7 and the thread number in bits 6..0.
- R6: The physical ring matches when its valid bit is set and thr_hw_id equals an identifier built in the same layout from req_blk as the chip number and req_idx[6:0] as the thread number. Bits of req_idx above bit 6 do not affect this match.
- R7: With req_fmt = 0 and req_ign = 0, the rings are tried in the order physical, pool, OS, and the first one that matches is reported.
- R8: With req_fmt = 0 and req_ign = 1, the result is a miss whatever the ring contents.
- R9: With req_fmt = 1, only the user ring can hit. It needs all of the following: the OS ring valid, the OS ring's stored word equal to the target identifier, the user valid bit set, and the stored logical-server number equal to req_ls. In this format req_ign has no effect.
- R10: The result is registered. res_vld is high exactly in the cycle after a cycle with req_vld high. res_ring is 0 user, 1 OS, 2 pool or 3 physical on a hit and 0 on a miss. res_hit and res_ring hold their values while no request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_mode | input | 1 | Static block-grouping mode for the hardwired identifier |
| proc_id | input | 16 | Thread's processor identification value (static) |
| wr_en | input | 1 | Ring write strobe |
| wr_ring | input | 2 | Ring to write: 0 user, 1 OS, 2 pool, 3 physical |
| wr_vld | input | 1 | Valid bit written to the ring |
| wr_data | input | 23 | Identifier word, or logical-server number in bits 11..0 for the user ring |
| req_vld | input | 1 | Notification request strobe |
| req_fmt | input | 1 | Request format: 0 specific target, 1 user-level |
| req_ign | input | 1 | Logical-server (ignore) bit |
| req_blk | input | 4 | Target block |
| req_idx | input | 19 | Target index |
| req_ls | input | 12 | Logical-server number |
| res_vld | output | 1 | Result strobe, one cycle after a request |
| res_hit | output | 1 | The request targets this thread |
| res_ring | output | 2 | Matched ring code |
| thr_hw_id | output | 23 | Hardwired physical identifier of this thread |

## Verification
The result of a request is due exactly one clock after the edge that samples req_vld. The bench drives each request on a falling edge, drops it on the next falling edge and compares res_vld, res_hit and res_ring at that moment, half a cycle after the register has loaded. A ring write driven on a falling edge takes effect at the rising edge that follows, so the first request that can see it is the one driven on the next falling edge. The same-cycle test drives a write and a request together and expects the old contents. thr_hw_id depends only on static inputs, so it is checked on the falling edge after those inputs change.

// File: rtl/tcm_pkg.sv
// Shared ring encoding and default widths for the thread context matcher.
// Assumes the ring code is also the write-port ring selector.
package tcm_pkg;
    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

    localparam int NUM_RINGS     = 4;
    localparam int BLK_W_DEF     = 4;
    localparam int IDX_W_DEF     = 19;
    localparam int LS_W_DEF      = 12;
    localparam int PID_W_DEF     = 16;
    localparam int CHIP_W_DEF    = 4;
    localparam int TID_W_DEF     = 7;
    localparam int PID_CHIP_LSB  = 8;
    localparam int HW_CHIP_LSB   = 11;
endpackage

// File: rtl/tcm_hw_id.sv
// Builds a hardwired physical identifier from a chip number and a thread
// number. In normal mode a marker bit sits just above the thread field and
// the chip field starts at CHIP_LSB; in grouping mode the chip field sits
// just above the thread field with the marker above it.
// Assumes CHIP_LSB >= TID_W + 1 and ID_W > CHIP_LSB + CHIP_W - 1.
module tcm_hw_id #(
    parameter int CHIP_W   = tcm_pkg::CHIP_W_DEF,
    parameter int TID_W    = tcm_pkg::TID_W_DEF,
    parameter int CHIP_LSB = tcm_pkg::HW_CHIP_LSB,
    parameter int ID_W     = 23
) (
    input  logic              grp,
    input  logic [CHIP_W-1:0] chip,
    input  logic [TID_W-1:0]  tid,
    output logic [ID_W-1:0]   id
);
    localparam int GRP_MARK = TID_W + CHIP_W;

    // Assemble the identifier fields for the selected layout.
    always_comb begin
        id = '0;
        id[TID_W-1:0] = tid;
        if (grp) begin
            id[TID_W +: CHIP_W] = chip;
            id[GRP_MARK]        = 1'b1;
        end else begin
            id[TID_W]              = 1'b1;
            id[CHIP_LSB +: CHIP_W] = chip;
        end
    end
endmodule

// File: rtl/tcm_ring_store.sv
// Holds the four ring contexts of one thread: a valid bit per ring, the
// identifier words of the OS and pool rings and the logical-server number
// of the user ring. One ring is written per cycle through the write port.
// Assumes LS_W <= ID_W; the physical ring keeps only its valid bit.
module tcm_ring_store #(
    parameter int ID_W = 23,
    parameter int LS_W = tcm_pkg::LS_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_ring,
    input  logic                         wr_vld,
    input  logic [ID_W-1:0]              wr_data,
    output logic [tcm_pkg::NUM_RINGS-1:0] ctx_vld,
    output logic [ID_W-1:0]              os_id,
    output logic [ID_W-1:0]              pool_id,
    output logic [LS_W-1:0]              user_ls
);
    import tcm_pkg::*;

    // One valid bit per ring, each with its own write decode.
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_vld
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctx_vld[r] <= 1'b0;
            else if (wr_en && wr_ring == 2'(r))
                ctx_vld[r] <= wr_vld;
        end
    end

    // OS ring identifier word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            os_id <= '0;
        else if (wr_en && wr_ring == RING_OS)
            os_id <= wr_data;
    end

    // Pool ring identifier word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pool_id <= '0;
        else if (wr_en && wr_ring == RING_POOL)
            pool_id <= wr_data;
    end

    // User ring logical-server number.
    always_ff @(posedge clk) begin
        if (!rst_n)
            user_ls <= '0;
        else if (wr_en && wr_ring == RING_USER)
            user_ls <= wr_data[LS_W-1:0];
    end

    // R2: a write lands the requested valid bit in the selected ring.
    p_write_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctx_vld[$past(wr_ring)] == $past(wr_vld));

    // R2: a ring not addressed by a write keeps its valid bit.
    p_other_ring_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ring != RING_OS) |=> $stable(ctx_vld[RING_OS]));
endmodule

// File: rtl/tcm_ring_select.sv
// Combinational match of one request against the ring contexts, with the
// fixed privilege order physical, pool, OS for specific-target requests and
// the user ring alone for user-level requests.
// Assumes the target identifier is {block, index}, i.e. block << IDX_W.
module tcm_ring_select #(
    parameter int BLK_W = tcm_pkg::BLK_W_DEF,
    parameter int IDX_W = tcm_pkg::IDX_W_DEF,
    parameter int LS_W  = tcm_pkg::LS_W_DEF,
    parameter int ID_W  = BLK_W + IDX_W
) (
    input  logic [tcm_pkg::NUM_RINGS-1:0] ctx_vld,
    input  logic [ID_W-1:0]               os_id,
    input  logic [ID_W-1:0]               pool_id,
    input  logic [LS_W-1:0]               user_ls,
    input  logic [ID_W-1:0]               thr_hw_id,
    input  logic [ID_W-1:0]               req_hw_id,
    input  logic                          req_fmt,
    input  logic                          req_ign,
    input  logic [BLK_W-1:0]              req_blk,
    input  logic [IDX_W-1:0]              req_idx,
    input  logic [LS_W-1:0]               req_ls,
    output logic                          hit,
    output tcm_pkg::ring_e                ring
);
    import tcm_pkg::*;

    logic [ID_W-1:0] target;
    logic            phys_hit;
    logic            pool_hit;
    logic            os_hit;
    logic            user_hit;

    // Form the virtual target identifier from block and index.
    assign target = {req_blk, req_idx};

    // Per-ring compare terms.
    always_comb begin
        phys_hit = ctx_vld[RING_PHYS] && (thr_hw_id == req_hw_id);
        pool_hit = ctx_vld[RING_POOL] && (pool_id == target);
        os_hit   = ctx_vld[RING_OS]   && (os_id == target);
        user_hit = os_hit && ctx_vld[RING_USER] && (user_ls == req_ls);
    end

    // Pick the winning ring by format and privilege order.
    always_comb begin
        hit  = 1'b0;
        ring = RING_USER;
        if (req_fmt) begin
            if (user_hit) begin
                hit  = 1'b1;
                ring = RING_USER;
            end
        end else if (!req_ign) begin
            if (phys_hit) begin
                hit  = 1'b1;
                ring = RING_PHYS;
            end else if (pool_hit) begin
                hit  = 1'b1;
                ring = RING_POOL;
            end else if (os_hit) begin
                hit  = 1'b1;
                ring = RING_OS;
            end
        end
    end
endmodule

// File: rtl/thread_ctx_matcher.sv
// Top of the thread context ring matcher. Holds the ring contexts of one
// thread, derives the thread's hardwired physical identifier, matches each
// request and registers the result one cycle after the request strobe.
// Assumes grp_mode and proc_id are static while requests are in flight.
module thread_ctx_matcher #(
    parameter int BLK_W  = tcm_pkg::BLK_W_DEF,
    parameter int IDX_W  = tcm_pkg::IDX_W_DEF,
    parameter int LS_W   = tcm_pkg::LS_W_DEF,
    parameter int PID_W  = tcm_pkg::PID_W_DEF,
    parameter int CHIP_W = tcm_pkg::CHIP_W_DEF,
    parameter int TID_W  = tcm_pkg::TID_W_DEF,
    parameter int ID_W   = BLK_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_mode,
    input  logic [PID_W-1:0] proc_id,
    input  logic             wr_en,
    input  logic [1:0]       wr_ring,
    input  logic             wr_vld,
    input  logic [ID_W-1:0]  wr_data,
    input  logic             req_vld,
    input  logic             req_fmt,
    input  logic             req_ign,
    input  logic [BLK_W-1:0] req_blk,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [LS_W-1:0]  req_ls,
    output logic             res_vld,
    output logic             res_hit,
    output logic [1:0]       res_ring,
    output logic [ID_W-1:0]  thr_hw_id
);
    import tcm_pkg::*;

    logic [NUM_RINGS-1:0] ctx_vld;
    logic [ID_W-1:0]      os_id;
    logic [ID_W-1:0]      pool_id;
    logic [LS_W-1:0]      user_ls;
    logic [ID_W-1:0]      req_hw_id;
    logic                 sel_hit;
    ring_e                sel_ring;
    logic                 unused_pid_bits;

    // Processor id bits outside the chip and thread fields take no part.
    assign unused_pid_bits = ^proc_id;

    tcm_ring_store #(
        .ID_W (ID_W),
        .LS_W (LS_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ring (wr_ring),
        .wr_vld  (wr_vld),
        .wr_data (wr_data),
        .ctx_vld (ctx_vld),
        .os_id   (os_id),
        .pool_id (pool_id),
        .user_ls (user_ls)
    );

    // Thread side: identifier wired from the processor identification value.
    tcm_hw_id #(
        .CHIP_W (CHIP_W),
        .TID_W  (TID_W),
        .ID_W   (ID_W)
    ) u_thr_id (
        .grp  (grp_mode),
        .chip (proc_id[PID_CHIP_LSB +: CHIP_W]),
        .tid  (proc_id[TID_W-1:0]),
        .id   (thr_hw_id)
    );

    // Request side: same layout built from the request's block and index.
    tcm_hw_id #(
        .CHIP_W (CHIP_W),
        .TID_W  (TID_W),
        .ID_W   (ID_W)
    ) u_req_id (
        .grp  (grp_mode),
        .chip (req_blk[CHIP_W-1:0]),
        .tid  (req_idx[TID_W-1:0]),
        .id   (req_hw_id)
    );

    tcm_ring_select #(
        .BLK_W (BLK_W),
        .IDX_W (IDX_W),
        .LS_W  (LS_W),
        .ID_W  (ID_W)
    ) u_select (
        .ctx_vld   (ctx_vld),
        .os_id     (os_id),
        .pool_id   (pool_id),
        .user_ls   (user_ls),
        .thr_hw_id (thr_hw_id),
        .req_hw_id (req_hw_id),
        .req_fmt   (req_fmt),
        .req_ign   (req_ign),
        .req_blk   (req_blk),
        .req_idx   (req_idx),
        .req_ls    (req_ls),
        .hit       (sel_hit),
        .ring      (sel_ring)
    );

    // Result strobe follows each request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_vld <= 1'b0;
        else
            res_vld <= req_vld;
    end

    // Hit flag and ring code load on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit  <= 1'b0;
            res_ring <= RING_USER;
        end else if (req_vld) begin
            res_hit  <= sel_hit;
            res_ring <= sel_ring;
        end
    end

    // R10: every request yields a result strobe in the next cycle.
    p_resp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R10: with no request, no strobe and the result holds.
    p_resp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!res_vld && $stable(res_hit) && $stable(res_ring)));

    // R8: a logical-server request never hits.
    p_ls_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_fmt && req_ign) |=> !res_hit);

    // R9: a user-level request can only report the user ring.
    p_user_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_fmt) |=> (!res_hit || res_ring == RING_USER));

    // R6: a physical hit needs a physical ring written valid.
    p_phys_needs_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit && res_ring == RING_PHYS) |-> $past(ctx_vld[RING_PHYS]));
endmodule

// File: tb/thread_ctx_matcher_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, write timing, identifier layouts and priority.
module thread_ctx_matcher_bench;
    typedef struct packed {
        logic        fmt;
        logic        ign;
        logic [3:0]  blk;
        logic [18:0] idx;
        logic [11:0] ls;
        logic        hit;
        logic [1:0]  ring;
        logic [3:0]  tag;
    } vec_t;

    // Contexts loaded before the table: physical valid (proc chip 5, thread
    // 0x2A), OS = {2, 0x01234}, pool = {3, 0x00777}, user ls = 0x05A.
    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b0, 4'd5, 19'h0002A, 12'h000, 1'b1, 2'd3, 4'd6},  // R6 physical
        '{1'b0, 1'b0, 4'd5, 19'h012AA, 12'h000, 1'b1, 2'd3, 4'd6},  // R6 high idx bits ignored
        '{1'b0, 1'b0, 4'd5, 19'h0002B, 12'h000, 1'b0, 2'd0, 4'd6},  // R6 thread differs
        '{1'b0, 1'b0, 4'd3, 19'h00777, 12'h000, 1'b1, 2'd2, 4'd3},  // R3 pool
        '{1'b0, 1'b0, 4'd2, 19'h01234, 12'h000, 1'b1, 2'd1, 4'd3},  // R3 OS
        '{1'b0, 1'b0, 4'd2, 19'h01235, 12'h000, 1'b0, 2'd0, 4'd3},  // R3 index differs
        '{1'b0, 1'b1, 4'd2, 19'h01234, 12'h000, 1'b0, 2'd0, 4'd8},  // R8 ignore set
        '{1'b1, 1'b0, 4'd2, 19'h01234, 12'h05A, 1'b1, 2'd0, 4'd9},  // R9 user
        '{1'b1, 1'b0, 4'd2, 19'h01234, 12'h05B, 1'b0, 2'd0, 4'd9},  // R9 ls differs
        '{1'b1, 1'b0, 4'd3, 19'h00777, 12'h05A, 1'b0, 2'd0, 4'd9},  // R9 pool id not used
        '{1'b1, 1'b0, 4'd5, 19'h0002A, 12'h05A, 1'b0, 2'd0, 4'd9},  // R9 physical not used
        '{1'b1, 1'b1, 4'd2, 19'h01234, 12'h05A, 1'b1, 2'd0, 4'd9}   // R9 ignore no effect
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_mode = 1'b0;
    logic [15:0] proc_id = 16'h052A;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ring = 2'd0;
    logic        wr_vld = 1'b0;
    logic [22:0] wr_data = '0;
    logic        req_vld = 1'b0;
    logic        req_fmt = 1'b0;
    logic        req_ign = 1'b0;
    logic [3:0]  req_blk = '0;
    logic [18:0] req_idx = '0;
    logic [11:0] req_ls = '0;
    logic        res_vld;
    logic        res_hit;
    logic [1:0]  res_ring;
    logic [22:0] thr_hw_id;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thread_ctx_matcher u_thread_ctx_matcher (
        .clk (clk), .rst_n (rst_n), .grp_mode (grp_mode), .proc_id (proc_id),
        .wr_en (wr_en), .wr_ring (wr_ring), .wr_vld (wr_vld), .wr_data (wr_data),
        .req_vld (req_vld), .req_fmt (req_fmt), .req_ign (req_ign),
        .req_blk (req_blk), .req_idx (req_idx), .req_ls (req_ls),
        .res_vld (res_vld), .res_hit (res_hit), .res_ring (res_ring),
        .thr_hw_id (thr_hw_id)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] r, input logic v, input logic [22:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ring = r; wr_vld = v; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_req(input logic f, input logic i, input logic [3:0] b,
                             input logic [18:0] x, input logic [11:0] l);
        req_vld = 1'b1; req_fmt = f; req_ign = i; req_blk = b; req_idx = x; req_ls = l;
    endtask

    task automatic do_req(input string tag, input logic f, input logic i,
                          input logic [3:0] b, input logic [18:0] x,
                          input logic [11:0] l, input logic eh, input logic [1:0] er);
        @(negedge clk);
        drive_req(f, i, b, x, l);
        @(negedge clk);
        req_vld = 1'b0;
        chk(tag, {29'd0, res_vld, res_hit, 1'b0}, {29'd0, 1'b1, eh, 1'b0});
        chk(tag, {30'd0, res_ring}, {30'd0, er});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the result
        chk("R1", {29'd0, res_vld, res_hit, 1'b0}, 32'd0);
        chk("R1", {30'd0, res_ring}, 32'd0);
        // R1: all rings invalid after reset
        do_req("R1", 1'b0, 1'b0, 4'd5, 19'h0002A, 12'h000, 1'b0, 2'd0);
        do_req("R1", 1'b0, 1'b0, 4'd0, 19'h00000, 12'h000, 1'b0, 2'd0);

        // R4: normal layout (chip 5, thread 0x2A)
        chk("R4", {9'd0, thr_hw_id}, 32'h28AA);
        proc_id = 16'hFF7F;
        @(negedge clk);
        chk("R4", {9'd0, thr_hw_id}, 32'h78FF);
        grp_mode = 1'b1;
        @(negedge clk);
        chk("R5", {9'd0, thr_hw_id}, 32'h0FFF);
        proc_id = 16'h052A;
        @(negedge clk);
        chk("R5", {9'd0, thr_hw_id}, 32'h0AAA);
        grp_mode = 1'b0;

        // R2: load the rings
        wr(2'd3, 1'b1, 23'h0);
        wr(2'd1, 1'b1, {4'd2, 19'h01234});
        wr(2'd2, 1'b1, {4'd3, 19'h00777});
        wr(2'd0, 1'b1, 23'h00005A);

        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            drive_req(VEC[k].fmt, VEC[k].ign, VEC[k].blk, VEC[k].idx, VEC[k].ls);
            @(negedge clk);
            req_vld = 1'b0;
            n_tests++;
            if (res_vld !== 1'b1 || res_hit !== VEC[k].hit || res_ring !== VEC[k].ring) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%b/%b/%0d expected=1/%b/%0d",
                         VEC[k].tag, k, res_vld, res_hit, res_ring, VEC[k].hit, VEC[k].ring);
            end
        end

        // R10: no strobe on an idle cycle, result holds (last was user hit)
        @(negedge clk);
        chk("R10", {29'd0, res_vld, res_hit, 1'b0}, {29'd0, 1'b0, 1'b1, 1'b0});

        // R6: physical match in grouping mode
        grp_mode = 1'b1;
        do_req("R6", 1'b0, 1'b0, 4'd5, 19'h0002A, 12'h000, 1'b1, 2'd3);
        do_req("R6", 1'b0, 1'b0, 4'd4, 19'h0002A, 12'h000, 1'b0, 2'd0);
        grp_mode = 1'b0;

        // R7: physical wins over pool for the same target
        wr(2'd2, 1'b1, {4'd5, 19'h0002A});
        do_req("R7", 1'b0, 1'b0, 4'd5, 19'h0002A, 12'h000, 1'b1, 2'd3);
        wr(2'd3, 1'b0, 23'h0);
        do_req("R7", 1'b0, 1'b0, 4'd5, 19'h0002A, 12'h000, 1'b1, 2'd2);
        // R7: pool wins over OS for the same target
        wr(2'd2, 1'b1, {4'd2, 19'h01234});
        do_req("R7", 1'b0, 1'b0, 4'd2, 19'h01234, 12'h000, 1'b1, 2'd2);
        wr(2'd2, 1'b0, {4'd2, 19'h01234});
        do_req("R7", 1'b0, 1'b0, 4'd2, 19'h01234, 12'h000, 1'b1, 2'd1);

        // R2: request in the same cycle as a write sees the old contents
        @(negedge clk);
        wr_en = 1'b1; wr_ring = 2'd1; wr_vld = 1'b0; wr_data = {4'd2, 19'h01234};
        drive_req(1'b0, 1'b0, 4'd2, 19'h01234, 12'h000);
        @(negedge clk);
        wr_en = 1'b0; req_vld = 1'b0;
        chk("R2", {30'd0, res_hit, 1'b0}, {30'd0, 1'b1, 1'b0});
        chk("R2", {30'd0, res_ring}, 32'd1);
        do_req("R2", 1'b0, 1'b0, 4'd2, 19'h01234, 12'h000, 1'b0, 2'd0);

        // R9: user ring needs the OS ring valid
        do_req("R9", 1'b1, 1'b0, 4'd2, 19'h01234, 12'h05A, 1'b0, 2'd0);

        // R10: back-to-back requests each get a result
        @(negedge clk);
        wr_en = 1'b1; wr_ring = 2'd1; wr_vld = 1'b1; wr_data = {4'd2, 19'h01234};
        @(negedge clk);
        wr_en = 1'b0;
        drive_req(1'b0, 1'b0, 4'd2, 19'h01234, 12'h000);
        @(negedge clk);
        chk("R10", {30'd0, res_vld, res_hit}, 32'd3);
        drive_req(1'b0, 1'b0, 4'd2, 19'h01235, 12'h000);
        @(negedge clk);
        req_vld = 1'b0;
        chk("R10", {30'd0, res_vld, res_hit}, 32'd2);
        chk("R10", {30'd0, res_ring}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule